// File: doc/BRIEF.md
# ACK Coalescing Latency Timer

This block decides when the data link layer should acknowledge received transactions, and at what priority. The first transaction that has not been acknowledged starts a tick counter. When the counter reaches a programmable limit, the block raises an urgent acknowledge request. Before that point, if the transmitter has no outgoing transactions, the block offers the acknowledge as a low-priority request instead. Transactions that arrive while an acknowledge is still pending are folded into that same acknowledge. The request always carries the most recent good sequence number.

The limit is an 8-bit value counted in link clock ticks. At reset it takes a default chosen from the configured link width, and a register write can replace it later. A received duplicate transaction makes the pending acknowledge urgent at once. The block does not build the acknowledge packet and does not arbitrate it against other traffic. The arbiter outside the block grants a request, and the grant clears the pending state.

Top module: `ack_coalesce_timer`

## Requirements
- R1: After reset, ack_urgent_o and ack_lowpri_o are 0 and ack_seq_o is 0.
- R2: While rst_ni is low, the limit loads a default from link_width_i: 0 gives 255, 1 gives 128, 2 gives 64, 3 gives 32. Suppose a transaction is sampled at clock edge k and nothing is granted. Then ack_urgent_o is 0 after edge k+L-1 and 1 after edge k+L, where L is the effective limit.
- R3: A write (cfg_we_i high) loads cfg_wdata_i into the limit from the next edge. A stored value of 0 or 1 acts as 255. A stored value of 2 to 255 acts as itself.
- R4: ack_seq_o equals the sequence number of the latest transaction accepted with rx_dup_i low. A duplicate does not change it.
- R5: A transaction accepted with rx_dup_i high makes ack_urgent_o 1 after the next edge, whatever the counter value.
- R6: ack_lowpri_o is 1 only when an acknowledge is pending, ack_urgent_o is 0, and tx_busy_i is 0. The two request outputs are never both 1.
- R7: A transaction that arrives while an acknowledge is pending does not restart the counter. Urgency still comes L edges after the first transaction.
- R8: If ack_grant_i is high while a request is asserted, both requests are 0 after that edge. A transaction sampled in the same cycle starts a fresh count from that edge.
- R9: With no acknowledge pending, no request is raised, whatever the value of tx_busy_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Link clock, one tick per symbol time |
| rst_ni | input | 1 | Asynchronous active-low reset |
| link_width_i | input | 2 | Link width code that selects the reset default of the limit |
| cfg_we_i | input | 1 | Limit register write enable |
| cfg_wdata_i | input | 8 | Limit register write data |
| rx_valid_i | input | 1 | A received transaction needs acknowledging |
| rx_seq_i | input | 12 | Sequence number of the received transaction |
| rx_dup_i | input | 1 | The received transaction is a duplicate |
| tx_busy_i | input | 1 | The transmitter has outgoing transactions |
| ack_grant_i | input | 1 | Arbiter grant for the current acknowledge request |
| ack_urgent_o | output | 1 | High-priority acknowledge request |
| ack_lowpri_o | output | 1 | Low-priority acknowledge request |
| ack_seq_o | output | 12 | Sequence number to acknowledge |

## Verification
The bench builds the block with its default parameters: a 12-bit sequence and an 8-bit limit. With these, the saturating counter reaches its full range of 255, so both the alias for values 0 and 1 and the largest wait are exercised directly. The bench resets the block once for each of the four width codes, so every reset default is timed against the exact edge of urgency. Written limits of 2 and 200 cover the shortest wait and an intermediate one.

// File: rtl/ack_coal_pkg.sv
package ack_coal_pkg;
  localparam int LIM_W = 8;
  localparam int SEQ_W = 12;

  typedef enum logic [1:0] {
    LW_X1 = 2'd0,
    LW_X2 = 2'd1,
    LW_X4 = 2'd2,
    LW_X8 = 2'd3
  } link_w_e;

  function automatic logic [LIM_W-1:0] width_default(link_w_e w);
    case (w)
      LW_X1:   width_default = '1;
      LW_X2:   width_default = LIM_W'(1) << (LIM_W - 1);
      LW_X4:   width_default = LIM_W'(1) << (LIM_W - 2);
      default: width_default = LIM_W'(1) << (LIM_W - 3);
    endcase
  endfunction
endpackage

// File: rtl/ack_lim_reg.sv
module ack_lim_reg
  import ack_coal_pkg::*;
#(
  parameter int W = LIM_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [1:0]   width_i,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] eff_lim_o
);
  localparam logic [W-1:0] MIN_EFF = W'(2);

  logic [W-1:0] raw_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   raw_q <= width_default(link_w_e'(width_i));
    else if (we_i) raw_q <= wdata_i;
  end

  // values below the smallest effective one alias to the full range
  assign eff_lim_o = (raw_q < MIN_EFF) ? '1 : raw_q;
endmodule

// File: rtl/ack_lat_cnt.sv
module ack_lat_cnt #(
  parameter int CW = 8,
  parameter int SW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ev_i,
  input  logic          dup_i,
  input  logic [SW-1:0] seq_i,
  input  logic          clear_i,
  output logic          pend_o,
  output logic          dup_o,
  output logic [CW-1:0] cnt_o,
  output logic [SW-1:0] seq_o
);
  logic          pend_q, dup_q;
  logic [CW-1:0] cnt_q;
  logic [SW-1:0] seq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      dup_q  <= 1'b0;
      cnt_q  <= '0;
      seq_q  <= '0;
    end else begin
      if (clear_i) begin
        pend_q <= 1'b0;
        dup_q  <= 1'b0;
        cnt_q  <= '0;
      end else if (pend_q && cnt_q != '1) begin
        cnt_q <= cnt_q + 1'b1;
      end
      if (ev_i) begin
        pend_q <= 1'b1;
        // later arrivals merge into the running count
        if (!pend_q || clear_i) cnt_q <= '0;
        if (dup_i) dup_q <= 1'b1;
        else       seq_q <= seq_i;
      end
    end
  end

  assign pend_o = pend_q;
  assign dup_o  = dup_q;
  assign cnt_o  = cnt_q;
  assign seq_o  = seq_q;
endmodule

// File: rtl/ack_req_sel.sv
module ack_req_sel #(
  parameter int CW = 8
) (
  input  logic          pend_i,
  input  logic          dup_i,
  input  logic [CW-1:0] cnt_i,
  input  logic [CW-1:0] lim_i,
  input  logic          busy_i,
  input  logic          grant_i,
  output logic          urgent_o,
  output logic          lowpri_o,
  output logic          clear_o
);
  always_comb begin
    urgent_o = pend_i && (dup_i || cnt_i >= lim_i);
    lowpri_o = pend_i && !urgent_o && !busy_i;
    clear_o  = grant_i && (urgent_o || lowpri_o);
  end
endmodule

// File: rtl/ack_coalesce_timer.sv
module ack_coalesce_timer
  import ack_coal_pkg::*;
#(
  parameter int SW = SEQ_W,
  parameter int CW = LIM_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    link_width_i,
  input  logic          cfg_we_i,
  input  logic [CW-1:0] cfg_wdata_i,
  input  logic          rx_valid_i,
  input  logic [SW-1:0] rx_seq_i,
  input  logic          rx_dup_i,
  input  logic          tx_busy_i,
  input  logic          ack_grant_i,
  output logic          ack_urgent_o,
  output logic          ack_lowpri_o,
  output logic [SW-1:0] ack_seq_o
);
  logic [CW-1:0] eff_lim, cnt;
  logic          pend, dup, clear;

  ack_lim_reg #(.W(CW)) u_lim (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .width_i   (link_width_i),
    .we_i      (cfg_we_i),
    .wdata_i   (cfg_wdata_i),
    .eff_lim_o (eff_lim)
  );

  ack_lat_cnt #(.CW(CW), .SW(SW)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ev_i    (rx_valid_i),
    .dup_i   (rx_dup_i),
    .seq_i   (rx_seq_i),
    .clear_i (clear),
    .pend_o  (pend),
    .dup_o   (dup),
    .cnt_o   (cnt),
    .seq_o   (ack_seq_o)
  );

  ack_req_sel #(.CW(CW)) u_sel (
    .pend_i   (pend),
    .dup_i    (dup),
    .cnt_i    (cnt),
    .lim_i    (eff_lim),
    .busy_i   (tx_busy_i),
    .grant_i  (ack_grant_i),
    .urgent_o (ack_urgent_o),
    .lowpri_o (ack_lowpri_o),
    .clear_o  (clear)
  );
endmodule

// File: rtl/ack_coalesce_timer_chk.sv
module ack_coalesce_timer_chk #(
  parameter int SW = 12,
  parameter int CW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cfg_we_i,
  input logic          rx_valid_i,
  input logic [SW-1:0] rx_seq_i,
  input logic          rx_dup_i,
  input logic          tx_busy_i,
  input logic          ack_grant_i,
  input logic          ack_urgent_o,
  input logic          ack_lowpri_o,
  input logic [SW-1:0] ack_seq_o
);
  p_excl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ack_urgent_o && ack_lowpri_o));

  p_busy_blocks_low_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_busy_i |-> !ack_lowpri_o);

  p_dup_urgent_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && rx_dup_i) |=> ack_urgent_o);

  p_seq_track_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && !rx_dup_i) |=> ack_seq_o == $past(rx_seq_i));

  p_dup_keeps_seq_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(rx_valid_i && !rx_dup_i)) |=> $stable(ack_seq_o));

  p_grant_clears_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_grant_i && (ack_urgent_o || ack_lowpri_o) && !rx_valid_i)
      |=> !ack_urgent_o && !ack_lowpri_o);

  p_urgent_holds_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_urgent_o && !ack_grant_i && !cfg_we_i) |=> ack_urgent_o);
endmodule

bind ack_coalesce_timer ack_coalesce_timer_chk #(.SW(SW), .CW(CW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cfg_we_i     (cfg_we_i),
  .rx_valid_i   (rx_valid_i),
  .rx_seq_i     (rx_seq_i),
  .rx_dup_i     (rx_dup_i),
  .tx_busy_i    (tx_busy_i),
  .ack_grant_i  (ack_grant_i),
  .ack_urgent_o (ack_urgent_o),
  .ack_lowpri_o (ack_lowpri_o),
  .ack_seq_o    (ack_seq_o)
);

// File: tb/tb_ack_coalesce_timer.sv
module tb_ack_coalesce_timer;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  link_width = 2'd0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_wdata = '0;
  logic        rx_valid = 1'b0;
  logic [11:0] rx_seq = '0;
  logic        rx_dup = 1'b0;
  logic        tx_busy = 1'b1;
  logic        grant = 1'b0;
  logic        urg, low;
  logic [11:0] seq;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  typedef struct {
    string       rid;
    logic        u;
    logic        l;
    logic [11:0] s;
  } exp_t;
  exp_t exp_q[$];

  always #4 clk = ~clk;

  ack_coalesce_timer dut (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .link_width_i (link_width),
    .cfg_we_i     (cfg_we),
    .cfg_wdata_i  (cfg_wdata),
    .rx_valid_i   (rx_valid),
    .rx_seq_i     (rx_seq),
    .rx_dup_i     (rx_dup),
    .tx_busy_i    (tx_busy),
    .ack_grant_i  (grant),
    .ack_urgent_o (urg),
    .ack_lowpri_o (low),
    .ack_seq_o    (seq)
  );

  // monitor: compare queued expectations late in the low phase
  always @(negedge clk) begin
    #3;
    while (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      checks++;
      if (urg !== e.u || low !== e.l || seq !== e.s) begin
        errors++;
        $display("FAIL %s: urg/low/seq actual=%0b/%0b/%0d expected=%0b/%0b/%0d",
                 e.rid, urg, low, seq, e.u, e.l, e.s);
      end
    end
  end

  task automatic cyc(input logic v, input logic [11:0] s, input logic d,
                     input logic b, input logic g,
                     input logic we = 1'b0, input logic [7:0] wd = 8'd0);
    @(negedge clk);
    rx_valid = v; rx_seq = s; rx_dup = d;
    tx_busy = b; grant = g; cfg_we = we; cfg_wdata = wd;
  endtask

  task automatic expect_now(input string rid, input logic u, input logic l,
                            input logic [11:0] s);
    exp_t e;
    #1;
    e.rid = rid; e.u = u; e.l = l; e.s = s;
    exp_q.push_back(e);
  endtask

  task automatic do_reset(input logic [1:0] w);
    @(negedge clk);
    rst_ni = 1'b0; link_width = w;
    rx_valid = 1'b0; rx_dup = 1'b0; tx_busy = 1'b1; grant = 1'b0; cfg_we = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
  endtask

  // TLP at edge k; urgency expected exactly lim edges later
  task automatic t_limit(input string rid, input int lim, input logic [11:0] s0,
                         input bit merge);
    logic [11:0] s_exp;
    s_exp = s0;
    cyc(1'b1, s0, 1'b0, 1'b1, 1'b0);
    for (int j = 1; j <= lim + 1; j++) begin
      if (merge && j == 5) begin
        cyc(1'b1, s0 + 12'd1, 1'b0, 1'b1, 1'b0);
        s_exp = s0 + 12'd1;
      end else begin
        cyc(1'b0, 12'd0, 1'b0, 1'b1, 1'b0);
      end
      if (j == lim)     expect_now(rid, 1'b0, 1'b0, j > 5 ? s_exp : s0);
      if (j == lim + 1) expect_now(rid, 1'b1, 1'b0, s_exp);
    end
    cyc(1'b0, 12'd0, 1'b0, 1'b1, 1'b1);
    expect_now({rid, " R8 grant"}, 1'b1, 1'b0, s_exp);
    cyc(1'b0, 12'd0, 1'b0, 1'b1, 1'b0);
    expect_now({rid, " R8 cleared"}, 1'b0, 1'b0, s_exp);
  endtask

  initial begin
    do_reset(2'd2);
    cyc(0, 0, 0, 1, 0); expect_now("R1 reset", 0, 0, 0);
    cyc(0, 0, 0, 0, 0); expect_now("R9 idle not busy", 0, 0, 0);

    t_limit("R2 x4 R7 merge", 64, 12'd5, 1'b1);

    // R6 low-priority path
    cyc(1, 12'd9, 0, 0, 0);
    cyc(0, 0, 0, 0, 0); expect_now("R6 low when idle tx", 0, 1, 9);
    cyc(0, 0, 0, 1, 0); expect_now("R6 busy suppresses", 0, 0, 9);
    cyc(0, 0, 0, 0, 1); expect_now("R6 low granted", 0, 1, 9);
    cyc(0, 0, 0, 0, 0); expect_now("R9 after low grant", 0, 0, 9);

    // R5 duplicate
    cyc(1, 12'd77, 1, 1, 0);
    cyc(0, 0, 0, 1, 0); expect_now("R5 dup urgent R4 seq kept", 1, 0, 9);
    cyc(0, 0, 0, 1, 1); expect_now("R5 dup granted", 1, 0, 9);
    cyc(0, 0, 0, 1, 0); expect_now("R8 dup cleared", 0, 0, 9);

    // R3 writes
    cyc(0, 0, 0, 1, 0, 1'b1, 8'd1);
    t_limit("R3 wr1", 255, 12'd30, 1'b0);
    cyc(0, 0, 0, 1, 0, 1'b1, 8'd0);
    t_limit("R3 wr0", 255, 12'd31, 1'b0);
    cyc(0, 0, 0, 1, 0, 1'b1, 8'd200);
    t_limit("R3 wr200", 200, 12'd32, 1'b0);
    cyc(0, 0, 0, 1, 0, 1'b1, 8'd2);
    t_limit("R3 wr2", 2, 12'd40, 1'b0);

    // R8 restart on grant with concurrent TLP, limit 2
    cyc(1, 12'd50, 0, 1, 0);
    cyc(0, 0, 0, 1, 0);
    cyc(0, 0, 0, 1, 0); expect_now("R8 pre", 0, 0, 50);
    cyc(0, 0, 0, 1, 0); expect_now("R8 urgent", 1, 0, 50);
    cyc(1, 12'd51, 0, 1, 1); expect_now("R8 grant+tlp", 1, 0, 50);
    cyc(0, 0, 0, 1, 0); expect_now("R8 restarted", 0, 0, 51);
    cyc(0, 0, 0, 1, 0); expect_now("R8 restarted cnt1", 0, 0, 51);
    cyc(0, 0, 0, 1, 0); expect_now("R8 restarted urgent", 1, 0, 51);
    cyc(0, 0, 0, 1, 1);
    cyc(0, 0, 0, 1, 0); expect_now("R8 final clear", 0, 0, 51);

    // R2 remaining width defaults
    do_reset(2'd0);
    t_limit("R2 x1", 255, 12'd100, 1'b0);
    do_reset(2'd1);
    t_limit("R2 x2", 128, 12'd101, 1'b0);
    do_reset(2'd3);
    t_limit("R2 x8", 32, 12'd102, 1'b0);

    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule